// File: doc/BRIEF.md
# Serial Receiver with Per-Character Line Status

This block is the receive half of an asynchronous serial port together with the status logic that software polls. It samples the serial input on a 16x oversampling enable and frames characters with a start bit, 8 data bits sent LSB first, an optional parity bit (even or odd) and one stop bit. Each finished character is stored in a receive queue together with three error tags: framing, parity and break. A line status byte reports the tags of the character at the head of the queue, plus a sticky overrun flag, a summary flag that says an errored character was stored, and two transmitter flags that come directly from status inputs.

Software uses a small register port with a 3-bit address and single-cycle read and write strobes. Read data is combinational from the address. Reading the data address removes the head character. Reading the status address hides the head tags until the next removal, and it clears the overrun flag and, when the queue holds no errored character, the summary flag. A scratch byte can be written and read freely.

Top module: `uartRxLineStatus`

## Requirements
- R1: After reset the queue is empty. The status byte shows only the transmitter flags, the scratch byte reads 0x00 and the data address reads 0x00.
- R2: A character with a valid stop bit is stored. Reading address 0 returns its 8 data bits (the first serial bit is bit 0) and removes it. Characters come out in arrival order. Address 0 reads 0x00 when the queue is empty.
- R3: A low pulse on the serial line that has ended before the mid-bit sample (oversample count 7 after start detection) produces no character, and the receiver still accepts the characters that follow.
- R4: When parity is enabled, the parity bit follows the 8 data bits. Even mode expects the XOR of the data bits, odd mode expects its inverse. A mismatch sets status bit 2 for that character.
- R5: A character whose stop bit samples 0, and which is not a break, is stored with status bit 1 set. The bad stop bit is then taken as the start bit of the next character, so the bits that follow right away form a new character.
- R6: A line held low through start, data, parity (if enabled) and stop stores one character 0x00 with status bit 3 set and bit 1 clear. No further character starts until the line has been high again.
- R7: Status bits 1 to 3 show the tags of the head character only. The tags of a later character appear once the characters ahead of it have been removed.
- R8: A status read hides the head's tag bits 1 to 3 until that character is removed.
- R9: Status bit 5 sets when an errored character is stored. A status read clears it only if no errored character remains in the queue. If an errored character is stored in the same cycle as a status read, the bit stays set. The bit reads 0 while the queue is disabled.
- R10: The queue holds 16 characters when enabled (fifoEn=1) and 1 when disabled. A character that arrives while the queue is full is dropped and the stored characters are kept. The drop sets status bit 4, and the next status read clears it.
- R11: Status bit 6 equals holdEmptyIn. Status bit 7 equals holdEmptyIn AND shiftEmptyIn.
- R12: The scratch byte at address 6 reads back the last value written to it. Writing it, or writing to any other address, has no effect on the status byte or the queue.
- R13: Status bit 0 is 1 exactly when the queue holds at least one character. The status byte is at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Serial receive line, idle high |
| sampleTick | input | 1 | Oversampling enable, 16 per bit time |
| parityEn | input | 1 | A parity bit follows the data bits |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| fifoEn | input | 1 | 1 gives a 16-deep queue, 0 gives a single entry |
| regAddr | input | 3 | Register address: 0 data, 3 status, 6 scratch |
| regRead | input | 1 | Read strobe; its side effects happen at the clock edge |
| regWrite | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| holdEmptyIn | input | 1 | Transmit holding register is empty |
| shiftEmptyIn | input | 1 | Transmit shift register is empty |
| regRdata | output | 8 | Read data for regAddr |

## Verification
Two functions can act in the same clock edge: storing a character with a parity error, and a status read that would clear the summary flag. To force the overlap, the bench holds the status read strobe high on every cycle while the errored character is received, so one of those reads falls on the storing edge. The first read that shows status bit 0 set must also show bit 5 set. Later reads must keep bit 5 set until the character has been removed and one more status read has been made.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  localparam logic [2:0] ADDR_DATA    = 3'd0;
  localparam logic [2:0] ADDR_STATUS  = 3'd3;
  localparam logic [2:0] ADDR_SCRATCH = 3'd6;

  typedef struct packed {
    logic brk;
    logic parity;
    logic framing;
  } rxTagsT;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    rxTagsT            tags;
  } rxEntryT;

  typedef struct packed {
    logic    push;
    logic    drop;
    logic    pop;
    logic    statusRead;
    logic    scratchWrite;
    rxEntryT pushEntry;
  } ctrlStrobesT;
endpackage

// File: rtl/uartRxControl.sv
module uartRxControl
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxLine,
  input  logic        sampleTick,
  input  logic        parityEn,
  input  logic        parityOdd,
  input  logic [2:0]  regAddr,
  input  logic        regRead,
  input  logic        regWrite,
  input  logic        fifoEmpty,
  input  logic        fifoFull,
  output ctrlStrobesT strobes
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_BRKWAIT
  } rxStateT;

  rxStateT           state;
  logic              rxMeta, rxSync;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic              allZero;
  logic              pushPending;
  rxEntryT           pushEntryQ;
  logic              parityBad;

  assign parityBad = parityEn & (parBit != ((^shiftReg) ^ parityOdd));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= RX_IDLE;
      cnt         <= '0;
      bitIdx      <= '0;
      shiftReg    <= '0;
      parBit      <= 1'b0;
      allZero     <= 1'b0;
      pushPending <= 1'b0;
      pushEntryQ  <= '0;
    end else begin
      pushPending <= 1'b0;
      if (sampleTick) begin
        unique case (state)
          RX_IDLE: begin
            if (!rxSync) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == MID_CNT) begin
              cnt     <= '0;
              bitIdx  <= '0;
              allZero <= 1'b1;
              state   <= rxSync ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == LAST_CNT) begin
              cnt      <= '0;
              shiftReg <= {rxSync, shiftReg[DATA_W-1:1]};
              allZero  <= allZero & ~rxSync;
              bitIdx   <= bitIdx + 1'b1;
              if (bitIdx == LAST_BIT) state <= parityEn ? RX_PARITY : RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PARITY: begin
            if (cnt == LAST_CNT) begin
              cnt     <= '0;
              parBit  <= rxSync;
              allZero <= allZero & ~rxSync;
              state   <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == LAST_CNT) begin
              cnt             <= '0;
              pushPending     <= 1'b1;
              pushEntryQ.data <= shiftReg;
              if (rxSync) begin
                pushEntryQ.tags <= '{brk: 1'b0, parity: parityBad, framing: 1'b0};
                state           <= RX_IDLE;
              end else if (allZero) begin
                pushEntryQ.tags <= '{brk: 1'b1, parity: 1'b0, framing: 1'b0};
                state           <= RX_BRKWAIT;
              end else begin
                pushEntryQ.tags <= '{brk: 1'b0, parity: parityBad, framing: 1'b1};
                bitIdx          <= '0;
                allZero         <= 1'b1;
                state           <= RX_DATA;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_BRKWAIT: begin
            if (rxSync) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign strobes.push         = pushPending & ~fifoFull;
  assign strobes.drop         = pushPending & fifoFull;
  assign strobes.pop          = regRead && (regAddr == ADDR_DATA) && !fifoEmpty;
  assign strobes.statusRead   = regRead && (regAddr == ADDR_STATUS);
  assign strobes.scratchWrite = regWrite && (regAddr == ADDR_SCRATCH);
  assign strobes.pushEntry    = pushEntryQ;
endmodule

// File: rtl/uartRxDatapath.sv
module uartRxDatapath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic              fifoEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              holdEmptyIn,
  input  logic              shiftEmptyIn,
  output logic [DATA_W-1:0] regRdata,
  output logic              fifoEmpty,
  output logic              fifoFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] DEPTH_L  = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] ONE_L    = LVL_W'(1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rxEntryT           mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  level, errCount, capacity;
  logic              headMask, overrunFlag, anyErrFlag;
  logic [DATA_W-1:0] scratchReg;
  rxEntryT           headEntry;
  rxTagsT            shownTags;
  logic              pushErr, popErr;
  logic [DATA_W-1:0] statusByte;

  assign headEntry = mem[rdPtr];
  assign capacity  = fifoEn ? DEPTH_L : ONE_L;
  assign fifoEmpty = (level == '0);
  assign fifoFull  = (level >= capacity);
  assign pushErr   = strobes.push & (|strobes.pushEntry.tags);
  assign popErr    = strobes.pop & (|headEntry.tags);

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= strobes.pushEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      errCount <= '0;
    end else begin
      if (strobes.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobes.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      unique case ({strobes.push, strobes.pop})
        2'b10:   level <= level + ONE_L;
        2'b01:   level <= level - ONE_L;
        default: ;
      endcase
      unique case ({pushErr, popErr})
        2'b10:   errCount <= errCount + ONE_L;
        2'b01:   errCount <= errCount - ONE_L;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headMask    <= 1'b0;
      overrunFlag <= 1'b0;
      anyErrFlag  <= 1'b0;
      scratchReg  <= '0;
    end else begin
      if (strobes.pop) headMask <= 1'b0;
      else if (strobes.statusRead && !fifoEmpty) headMask <= 1'b1;

      if (strobes.drop) overrunFlag <= 1'b1;
      else if (strobes.statusRead) overrunFlag <= 1'b0;

      if (pushErr) anyErrFlag <= 1'b1;
      else if (strobes.statusRead && errCount == '0) anyErrFlag <= 1'b0;

      if (strobes.scratchWrite) scratchReg <= regWdata;
    end
  end

  assign shownTags  = (!fifoEmpty && !headMask) ? headEntry.tags : '0;
  assign statusByte = {holdEmptyIn & shiftEmptyIn, holdEmptyIn, anyErrFlag & fifoEn,
                       overrunFlag, shownTags.brk, shownTags.parity, shownTags.framing,
                       !fifoEmpty};

  always_comb begin
    unique case (regAddr)
      ADDR_DATA:    regRdata = fifoEmpty ? '0 : headEntry.data;
      ADDR_STATUS:  regRdata = statusByte;
      ADDR_SCRATCH: regRdata = scratchReg;
      default:      regRdata = '0;
    endcase
  end
endmodule

// File: rtl/uartRxLineStatus.sv
module uartRxLineStatus
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       sampleTick,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       fifoEn,
  input  logic [2:0] regAddr,
  input  logic       regRead,
  input  logic       regWrite,
  input  logic [7:0] regWdata,
  input  logic       holdEmptyIn,
  input  logic       shiftEmptyIn,
  output logic [7:0] regRdata
);
  ctrlStrobesT strobes;
  logic        fifoEmpty;
  logic        fifoFull;

  uartRxControl #(.OSR(OSR)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .parityEn(parityEn), .parityOdd(parityOdd), .regAddr(regAddr),
    .regRead(regRead), .regWrite(regWrite), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .strobes(strobes)
  );

  uartRxDatapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fifoEn(fifoEn),
    .regAddr(regAddr), .regWdata(regWdata), .holdEmptyIn(holdEmptyIn),
    .shiftEmptyIn(shiftEmptyIn), .regRdata(regRdata), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull)
  );
endmodule

// File: rtl/uartRxLineStatusChecker.sv
module uartRxLineStatusChecker
  import uart_rx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       fifoEn,
  input logic [2:0] regAddr,
  input logic       regRead,
  input logic       regWrite,
  input logic [7:0] regWdata,
  input logic [7:0] regRdata,
  input logic       holdEmptyIn,
  input logic       shiftEmptyIn,
  input logic       pushStrobe,
  input logic       dropStrobe,
  input logic       popStrobe,
  input logic       fifoEmpty,
  input logic       fifoFull
);
  assert_ready_flag_R13: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == ADDR_STATUS) |-> (regRdata[0] == !fifoEmpty));

  assert_tx_flags_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == ADDR_STATUS) |->
      (regRdata[7:6] == {holdEmptyIn & shiftEmptyIn, holdEmptyIn}));

  assert_summary_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == ADDR_STATUS && !fifoEn) |-> !regRdata[5]);

  assert_drop_keeps_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dropStrobe && !popStrobe) |=> (!fifoEmpty && fifoFull));

  assert_push_fills_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pushStrobe && !popStrobe) |=> !fifoEmpty);

  assert_empty_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == ADDR_DATA && fifoEmpty) |-> (regRdata == 8'h00));

  assert_scratch_back_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_SCRATCH) ##1 (regRead && regAddr == ADDR_SCRATCH)
      |-> (regRdata == $past(regWdata)));
endmodule

bind uartRxLineStatus uartRxLineStatusChecker chk_i (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .regAddr(regAddr), .regRead(regRead),
  .regWrite(regWrite), .regWdata(regWdata), .regRdata(regRdata),
  .holdEmptyIn(holdEmptyIn), .shiftEmptyIn(shiftEmptyIn),
  .pushStrobe(strobes.push), .dropStrobe(strobes.drop), .popStrobe(strobes.pop),
  .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
);

// File: tb/uartRxLineStatus_tb_top.sv
module uartRxLineStatus_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 16;
  localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd3, A_SCR = 3'd6;

  logic clk = 1'b0, rstN = 1'b0, rxLine = 1'b1, sampleTick = 1'b1;
  logic parityEn = 1'b0, parityOdd = 1'b0, fifoEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic regRead = 1'b0, regWrite = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic holdEmptyIn = 1'b0, shiftEmptyIn = 1'b0;
  int checks = 0, errors = 0;
  bit testDone = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uartRxLineStatus dut_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .parityEn(parityEn), .parityOdd(parityOdd), .fifoEn(fifoEn),
    .regAddr(regAddr), .regRead(regRead), .regWrite(regWrite),
    .regWdata(regWdata), .holdEmptyIn(holdEmptyIn), .shiftEmptyIn(shiftEmptyIn),
    .regRdata(regRdata)
  );

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    regRead = 1'b1;
    #1 v = regRdata;
    @(negedge clk);
    regRead = 1'b0;
  endtask

  task automatic expectReg(input string req, input string what, input logic [2:0] a,
                           input logic [7:0] exp);
    logic [7:0] v;
    readReg(a, v);
    check(req, what, v, exp);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr  = a;
    regWdata = d;
    regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic driveLevel(input logic b, input int n);
    rxLine = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] d, input logic withPar, input logic parVal,
                          input logic stopVal, input int idleBits);
    @(negedge clk);
    driveLevel(1'b0, BIT_CYC);
    for (int i = 0; i < 8; i++) driveLevel(d[i], BIT_CYC);
    if (withPar) driveLevel(parVal, BIT_CYC);
    driveLevel(stopVal, BIT_CYC);
    driveLevel(1'b1, idleBits * BIT_CYC);
  endtask

  function automatic logic goodPar(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!testDone) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit seen;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 and R11: reset state and transmitter flags
    expectReg("R1", "status after reset", A_STAT, 8'h00);
    expectReg("R1", "scratch after reset", A_SCR, 8'h00);
    expectReg("R1", "data after reset", A_DATA, 8'h00);
    for (int m = 0; m < 4; m++) begin
      holdEmptyIn  = m[0];
      shiftEmptyIn = m[1];
      expectReg("R11", "tx flags", A_STAT, {m[0] & m[1], m[0], 6'b0});
    end
    holdEmptyIn  = 1'b1;
    shiftEmptyIn = 1'b1;

    // R12: scratch byte, no side effects
    for (int i = 0; i < 8; i++) begin
      writeReg(A_SCR, 8'(8'hA5 ^ (8'h01 << i)));
      expectReg("R12", "scratch readback", A_SCR, 8'(8'hA5 ^ (8'h01 << i)));
    end
    writeReg(A_DATA, 8'h77);
    expectReg("R12", "status after writes", A_STAT, 8'hC0);
    expectReg("R12", "data after writes", A_DATA, 8'h00);

    // R2, R4, R13: every byte value, single-entry queue, parity mode alternating
    fifoEn   = 1'b0;
    parityEn = 1'b1;
    for (int d = 0; d < 256; d++) begin
      parityOdd = d[0];
      sendChar(8'(d), 1'b1, goodPar(8'(d), d[0]), 1'b1, 2);
      expectReg("R13", "status with one clean char", A_STAT, 8'hC1);
      expectReg("R2", "sweep data", A_DATA, 8'(d));
    end
    expectReg("R13", "status after sweep", A_STAT, 8'hC0);

    // R9: summary bit reads 0 with the queue disabled
    parityOdd = 1'b0;
    sendChar(8'h3C, 1'b1, ~goodPar(8'h3C, 1'b0), 1'b1, 2);
    expectReg("R9", "summary hidden when disabled", A_STAT, 8'hC5);
    expectReg("R4", "parity error char data", A_DATA, 8'h3C);
    expectReg("R9", "status cleared", A_STAT, 8'hC0);

    // R10: overrun with single entry
    sendChar(8'h11, 1'b1, goodPar(8'h11, 1'b0), 1'b1, 2);
    sendChar(8'h22, 1'b1, goodPar(8'h22, 1'b0), 1'b1, 2);
    expectReg("R10", "overrun single entry", A_STAT, 8'hD1);
    expectReg("R10", "overrun cleared by read", A_STAT, 8'hC1);
    expectReg("R10", "first char kept", A_DATA, 8'h11);
    expectReg("R10", "dropped char absent", A_STAT, 8'hC0);

    // R10 and R2: 16-deep queue, order, drop of the 17th
    fifoEn   = 1'b1;
    parityEn = 1'b0;
    for (int i = 0; i < 17; i++) sendChar(8'(8'h40 + i), 1'b0, 1'b0, 1'b1, 1);
    expectReg("R10", "overrun deep", A_STAT, 8'hD1);
    for (int i = 0; i < 16; i++) expectReg("R2", "queue order", A_DATA, 8'(8'h40 + i));
    expectReg("R10", "17th dropped", A_STAT, 8'hC0);

    // R4, R7, R8, R9: head tags, hide on read, summary clear rule
    parityEn  = 1'b1;
    parityOdd = 1'b0;
    sendChar(8'h3C, 1'b1, ~goodPar(8'h3C, 1'b0), 1'b1, 2);
    sendChar(8'h81, 1'b1, goodPar(8'h81, 1'b0), 1'b1, 2);
    expectReg("R7", "head parity tag", A_STAT, 8'hE5);
    expectReg("R8", "head tag hidden", A_STAT, 8'hE1);
    expectReg("R7", "first char", A_DATA, 8'h3C);
    expectReg("R9", "summary held until read", A_STAT, 8'hE1);
    expectReg("R9", "summary cleared", A_STAT, 8'hC1);
    expectReg("R7", "second char", A_DATA, 8'h81);
    expectReg("R7", "empty again", A_STAT, 8'hC0);
    parityOdd = 1'b1;
    sendChar(8'h07, 1'b1, ~goodPar(8'h07, 1'b1), 1'b1, 2);
    expectReg("R4", "odd parity error", A_STAT, 8'hE5);
    expectReg("R4", "odd char data", A_DATA, 8'h07);
    expectReg("R9", "summary after pop", A_STAT, 8'hE0);
    expectReg("R9", "summary gone", A_STAT, 8'hC0);

    // R5: framing error, then resync on the bad stop bit
    parityEn = 1'b0;
    sendChar(8'h5A, 1'b0, 1'b0, 1'b0, 0);
    for (int i = 0; i < 8; i++) driveLevel(1'(8'hC3 >> i), BIT_CYC);
    driveLevel(1'b1, 3 * BIT_CYC);
    expectReg("R5", "framing tag", A_STAT, 8'hE3);
    expectReg("R5", "framed char", A_DATA, 8'h5A);
    expectReg("R5", "resynced char clean", A_STAT, 8'hE1);
    expectReg("R5", "resynced char data", A_DATA, 8'hC3);
    expectReg("R5", "empty after resync", A_STAT, 8'hC0);

    // R6: long break yields one character
    driveLevel(1'b0, 30 * BIT_CYC);
    driveLevel(1'b1, 4 * BIT_CYC);
    expectReg("R6", "break tag", A_STAT, 8'hE9);
    expectReg("R6", "break data", A_DATA, 8'h00);
    expectReg("R6", "single break char", A_STAT, 8'hE0);
    expectReg("R6", "nothing more", A_STAT, 8'hC0);

    // R9: status read in the same cycle as an errored store
    parityEn  = 1'b1;
    parityOdd = 1'b0;
    seen      = 1'b0;
    fork
      sendChar(8'h55, 1'b1, ~goodPar(8'h55, 1'b0), 1'b1, 2);
      begin
        @(negedge clk);
        regAddr = A_STAT;
        regRead = 1'b1;
        repeat (200) begin
          @(negedge clk);
          #1;
          if (!seen && regRdata[0]) begin
            seen = 1'b1;
            check("R9", "summary on coincident read", {7'b0, regRdata[5]}, 8'h01);
          end
        end
        regRead = 1'b0;
      end
    join
    check("R9", "char seen while polling", {7'b0, seen}, 8'h01);
    expectReg("R9", "summary kept", A_STAT, 8'hE1);
    expectReg("R9", "polled char", A_DATA, 8'h55);
    expectReg("R9", "summary after pop", A_STAT, 8'hE0);
    expectReg("R9", "summary cleared", A_STAT, 8'hC0);

    // R3: short glitch ignored, receiver still alive
    @(negedge clk);
    driveLevel(1'b0, 4);
    driveLevel(1'b1, 4 * BIT_CYC);
    expectReg("R3", "glitch ignored", A_STAT, 8'hC0);
    sendChar(8'h96, 1'b1, goodPar(8'h96, 1'b0), 1'b1, 2);
    expectReg("R3", "char after glitch", A_DATA, 8'h96);

    testDone = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule